// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block places a clocked request/acknowledge port in front of an asynchronous pseudo-static RAM. The RAM has a 23-bit word address, a 16-bit data path, active-low strobes for chip select, output enable, write, address-valid and the two byte lanes, and a pin that sends a write to an internal setup register instead of to the array. The data path is split into a driven-out bus, a sampled-in bus and an output-enable flag, so the pad ring builds the tristate buffer.

When reset is released, the controller writes the refresh setup register once. That value travels on the address lines and turns on the RAM's fast in-page reads. After that the controller runs one access at a time: single-word reads, and writes that carry a per-byte mask. It remembers the 16-word page of the last read. A read that falls in the same page gets the short wait. Any other read gets the full access time. All wait counts are worked out from nanosecond parameters and the clock period.

A client raises `req` for one cycle while `busy` is low. It then waits for the one-cycle `ack` pulse, which for a read comes with valid `rdata`.

Top module: `psram_ctrl`

## Requirements
- R1: `busy` is high from reset until the setup write has finished. It goes low exactly 8 clock edges after reset is released (default timing). While reset is high, every RAM strobe is inactive (`memCeN` high).
- R2: After reset, exactly one setup write is issued: `memCre` high, `memWeN` low, `memOeN` high, `memCeN` low. `memAddr` carries 23'h000090: select field bits 19:18 = 00 (refresh register), bit 7 = 1 (fast page reads on), bit 4 = 1 (deep sleep off), and all other bits 0.
- R3: A read drives `memCeN`, `memAdvN` and `memOeN` low, with `memWeN` high and `memCre` low. `memBeN[i]` is low for each set `be[i]`. `rdata` returns the stored word together with `ack`.
- R4: A write holds `memCeN` and `memWeN` low with `memCre` low for 7 cycles (ceil(70 ns / 10 ns)). Its `ack` comes 7 edges after the accepting edge. Lane `be[0]` covers data bits 7:0 and `be[1]` covers bits 15:8. Unselected lanes, and the whole word when `be` is 00, stay unchanged.
- R5: A read whose address bits 22:4 differ from the last read, or that comes with no valid page record, waits ceil(70/10) = 7 cycles. Its `ack` comes 7 edges after the accepting edge.
- R6: A read whose bits 22:4 match the last read while the page record is valid waits ceil(max(20,20)/10) = 2 cycles. Its `ack` comes 2 edges after acceptance.
- R7: The page record is cleared by reset, by the setup write and by every write. The first read after a write always takes the long wait.
- R8: `memDataOe` is high only while a write strobe is active (`memWeN` low, `memCre` low), and it is high on every such cycle.
- R9: A read accepted right after a write gets one extra idle cycle before its strobes, giving a latency of 8 edges.
- R10: All strobes are inactive for at least one cycle between accesses. `ack` is a single-cycle pulse that falls in a cycle with `memCeN` high.
- R11: A `req` raised while `busy` is high is ignored. It produces no `ack` and does not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled while busy is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 23 | Word address |
| be | input | 2 | Byte lane mask, bit 1 = upper byte |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| busy | output | 1 | High while an access or setup is running |
| memClk | output | 1 | RAM clock, held low |
| memCeN | output | 1 | RAM chip select, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write strobe, active low |
| memAdvN | output | 1 | RAM address-valid, active low |
| memCre | output | 1 | Setup-register select, active high |
| memBeN | output | 2 | RAM byte lane enables, active low |
| memAddr | output | 23 | RAM address |
| memDataOut | output | 16 | Data driven toward the RAM |
| memDataOe | output | 1 | Enable for the data driver |
| memDataIn | input | 16 | Data returned by the RAM |

## Verification
Two functions can land in one cycle. A read can be accepted in the very cycle that the page record was cleared by a write, and then the turnaround and the wait choice meet. A stray request can also arrive during the idle cycle that carries `ack`. The bench provokes the first case by issuing a read to the same page as soon as a write is acknowledged, and checks that the latency is 8, not 2. It provokes the second by pulsing a write request in the middle of a read, then reads that word back and watches for a missing second `ack`. The RAM model in the bench returns a poison word whenever data is sampled before its own timing allows. So every latency check is also judged by the returned data.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic cre;
    logic drive;
    logic cfgSel;
    logic latch;
    logic capture;
    logic pageSet;
    logic pageClr;
  } memCtl_t;

  typedef enum logic [2:0] {
    ST_CFG,
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR,
    ST_GAP
  } ctlState_t;

  function automatic int unsigned cdiv(input int unsigned ns, input int unsigned clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // refresh setup value: select 00, fast page on, deep sleep off, full array
  function automatic logic [22:0] setupWord();
    logic [22:0] w;
    w = '0;
    w[19:18] = 2'b00;
    w[7] = 1'b1;
    w[4] = 1'b1;
    w[2:0] = 3'b000;
    return w;
  endfunction

endpackage

// File: rtl/psram_ctrl_fsm.sv
module psram_ctrl_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned LONG_NS = 70,
  parameter int unsigned PAGE_NS = 20,
  parameter int unsigned OE_NS   = 20,
  parameter int unsigned WP_NS   = 70
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    we,
  input  logic    pageHit,
  output memCtl_t ctl,
  output logic    busy,
  output logic    ack
);

  localparam int unsigned LONG_CYC = maxOf(cdiv(LONG_NS, CLK_NS), 1);
  localparam int unsigned PAGE_CYC = maxOf(maxOf(cdiv(PAGE_NS, CLK_NS), cdiv(OE_NS, CLK_NS)), 1);
  localparam int unsigned WR_CYC   = maxOf(cdiv(WP_NS, CLK_NS), 1);
  localparam int unsigned MAX_CYC  = maxOf(maxOf(LONG_CYC, PAGE_CYC), WR_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctlState_t state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] waitQ;
  logic lastWr;
  logic cfgDone;
  logic ackQ;

  wire rdDone = (cnt == waitQ - CNT_W'(1));
  wire wrDone = (cnt == CNT_W'(WR_CYC - 1));

  always_comb begin
    ctl = '0;
    if (!rst) begin
      case (state)
        ST_CFG: begin
          ctl.ce = 1'b1;
          ctl.we = 1'b1;
          ctl.cre = 1'b1;
          ctl.cfgSel = 1'b1;
          ctl.pageClr = 1'b1;
        end
        ST_IDLE: begin
          if (req) begin
            ctl.latch = 1'b1;
            ctl.pageClr = we;
            ctl.pageSet = !we;
          end
        end
        ST_RD: begin
          ctl.ce = 1'b1;
          ctl.oe = 1'b1;
          ctl.capture = rdDone;
        end
        ST_WR: begin
          ctl.ce = 1'b1;
          ctl.we = 1'b1;
          ctl.drive = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CFG;
      cnt <= '0;
      waitQ <= CNT_W'(LONG_CYC);
      lastWr <= 1'b0;
      cfgDone <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      ackQ <= 1'b0;
      case (state)
        ST_CFG: begin
          if (wrDone) begin
            cnt <= '0;
            cfgDone <= 1'b1;
            state <= ST_GAP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_IDLE: begin
          cnt <= '0;
          if (req) begin
            if (we) begin
              lastWr <= 1'b1;
              state <= ST_WR;
            end else begin
              waitQ <= pageHit ? CNT_W'(PAGE_CYC) : CNT_W'(LONG_CYC);
              lastWr <= 1'b0;
              state <= lastWr ? ST_TURN : ST_RD;
            end
          end
        end
        ST_TURN: state <= ST_RD;
        ST_RD: begin
          if (rdDone) begin
            cnt <= '0;
            ackQ <= 1'b1;
            state <= ST_GAP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WR: begin
          if (wrDone) begin
            cnt <= '0;
            ackQ <= 1'b1;
            state <= ST_GAP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign ack  = ackQ;

  a_r1_busy_until_setup: assert property (@(posedge clk) disable iff (rst)
    !cfgDone |-> busy);
  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    ctl.oe |-> (ctl.ce && !ctl.we && !ctl.cre));
  a_r10_ack_when_idle: assert property (@(posedge clk) disable iff (rst)
    ackQ |-> !ctl.ce);
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ackQ |=> !ackQ);
  a_r9_turn_after_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && $past(state) == ST_IDLE) |-> !$past(lastWr));

endmodule

// File: rtl/psram_ctrl_dp.sv
module psram_ctrl_dp
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  memCtl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              pageHit,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memAdvN,
  output logic              memCre,
  output logic [DATA_W/8-1:0] memBeN
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned TAG_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] SETUP = ADDR_W'(setupWord());

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [TAG_W-1:0]  tagQ;
  logic              tagValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      beQ <= '0;
      wdataQ <= '0;
    end else if (ctl.latch) begin
      addrQ <= addr;
      beQ <= be;
      wdataQ <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tagQ <= '0;
      tagValid <= 1'b0;
    end else if (ctl.pageClr) begin
      tagValid <= 1'b0;
    end else if (ctl.pageSet) begin
      tagQ <= addr[ADDR_W-1:PAGE_BITS];
      tagValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdataQ <= '0;
    else if (ctl.capture) rdataQ <= memDataIn;
  end

  assign pageHit = tagValid && (addr[ADDR_W-1:PAGE_BITS] == tagQ);
  assign rdata   = rdataQ;

  assign memAddr    = ctl.cfgSel ? SETUP : addrQ;
  assign memDataOut = wdataQ;
  assign memDataOe  = ctl.drive;
  assign memCeN     = !ctl.ce;
  assign memAdvN    = !ctl.ce;
  assign memOeN     = !ctl.oe;
  assign memWeN     = !ctl.we;
  assign memCre     = ctl.cre;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memBeN[i] = !(ctl.ce && !ctl.cre && beQ[i]);
  end

  a_r8_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    memDataOe |-> (!memWeN && !memCre && !memCeN));
  a_r8_write_drives: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && !memCre) |-> memDataOe);
  a_r2_setup_frame: assert property (@(posedge clk) disable iff (rst)
    (memCre && !memCeN) |-> (memAddr[19:18] == 2'b00 && memOeN && !memWeN));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned LONG_NS = 70,
  parameter int unsigned PAGE_NS = 20,
  parameter int unsigned OE_NS   = 20,
  parameter int unsigned WP_NS   = 70
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [22:0] addr,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        memClk,
  output logic        memCeN,
  output logic        memOeN,
  output logic        memWeN,
  output logic        memAdvN,
  output logic        memCre,
  output logic [1:0]  memBeN,
  output logic [22:0] memAddr,
  output logic [15:0] memDataOut,
  output logic        memDataOe,
  input  logic [15:0] memDataIn
);

  memCtl_t ctl;
  logic pageHit;

  psram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .LONG_NS(LONG_NS), .PAGE_NS(PAGE_NS),
    .OE_NS(OE_NS), .WP_NS(WP_NS)
  ) u_fsm (
    .clk(clk), .rst(rst), .req(req), .we(we), .pageHit(pageHit),
    .ctl(ctl), .busy(busy), .ack(ack)
  );

  psram_ctrl_dp #(
    .ADDR_W(23), .DATA_W(16), .PAGE_BITS(4)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .addr(addr), .be(be), .wdata(wdata),
    .memDataIn(memDataIn), .pageHit(pageHit), .rdata(rdata),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAdvN(memAdvN),
    .memCre(memCre), .memBeN(memBeN)
  );

  assign memClk = 1'b0;

endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int LONG_L = 7;
  localparam int PAGE_L = 2;
  localparam int WR_L   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic we = 1'b0;
  logic [22:0] addr = '0;
  logic [1:0] be = '0;
  logic [15:0] wdata = '0;
  logic ack, busy, memClk, memCeN, memOeN, memWeN, memAdvN, memCre, memDataOe;
  logic [15:0] rdata, memDataOut;
  logic [1:0] memBeN;
  logic [22:0] memAddr;
  logic [15:0] memDataIn;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_NS/2) clk = ~clk;

  psram_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .ack(ack), .rdata(rdata), .busy(busy), .memClk(memClk), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memAdvN(memAdvN), .memCre(memCre),
    .memBeN(memBeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [15:0] ram [int unsigned];
  logic [15:0] shadow [int unsigned];
  logic pmode = 1'b0;
  logic lastV = 1'b0;
  logic [22:0] lastA = '0, curA = '0, pA = '0;
  logic [15:0] pD = '0;
  logic [1:0] pBeN = 2'b11;
  logic pWeN = 1'b1, pCre = 1'b0, pOeN = 1'b1, pCeN = 1'b1;
  int rdCnt = 0, weCnt = 0, busErr = 0, setupCnt = 0;

  function automatic logic [15:0] ramRd(input logic [22:0] a);
    if (ram.exists(int'(a))) return ram[int'(a)];
    return 16'h0000;
  endfunction

  always_comb begin
    int needNs;
    needNs = (pmode && lastV && memAddr[22:4] == lastA[22:4]) ? 20 : 70;
    if (!memCeN && !memOeN && (rdCnt + 1) * CLK_NS >= needNs)
      memDataIn = ramRd(memAddr);
    else
      memDataIn = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (memDataOe && (!memOeN || memWeN || memCre)) busErr++;
    if (!memCeN && !memWeN && !memCre && !memDataOe) busErr++;
    if (!pWeN && memWeN && !pCeN) begin
      if (pCre) begin
        setupCnt++;
        chk(pA == 23'h000090 && pOeN, "R2", "setup word", pA, 23'h000090);
        if (pA[19:18] == 2'b00) pmode <= pA[7];
      end else begin
        chk(weCnt >= WR_L, "R4", "write pulse cycles", weCnt, WR_L);
        if (!pBeN[0]) ram[int'(pA)] = {ramRd(pA)[15:8], pD[7:0]};
        if (!pBeN[1]) ram[int'(pA)] = {pD[15:8], ramRd(pA)[7:0]};
      end
    end
    rdCnt <= (!memCeN && !memOeN) ? rdCnt + 1 : 0;
    weCnt <= (!memCeN && !memWeN) ? weCnt + 1 : 0;
    if (!memCeN) curA <= memAddr;
    if (memCeN && !pCeN) begin
      lastA <= curA;
      lastV <= 1'b1;
    end
    pWeN <= memWeN; pCre <= memCre; pOeN <= memOeN; pCeN <= memCeN;
    pA <= memAddr; pD <= memDataOut; pBeN <= memBeN;
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit wr, input logic [22:0] a, input logic [1:0] b,
                        input logic [15:0] d, output int lat, output logic [15:0] rd);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = wr; addr = a; be = b; wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      if (!ack) lat++;
    end while (!ack && lat < 100);
    rd = rdata;
    if (wr) begin
      if (b[0]) shadow[int'(a)] = {shadow[int'(a)][15:8], d[7:0]};
      if (b[1]) shadow[int'(a)] = {d[15:8], shadow[int'(a)][7:0]};
    end
  endtask

  function automatic logic [15:0] patt(input logic [22:0] a);
    return 16'((int'(a) * 40503) ^ 23130);
  endfunction

  function automatic logic [22:0] pageAddr(input int p, input int off);
    logic [18:0] pg;
    pg = (p == 0) ? 19'h0 : (p == 1) ? 19'h1 : 19'h7FFFF;
    return {pg, 4'(off)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat, cnt, extra;
    logic [15:0] rd;
    logic [22:0] a;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
    chk(memCeN == 1'b1, "R1", "chip select in reset", memCeN, 1);
    rst = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (busy && cnt < 100);
    chk(cnt == 8, "R1", "edges until busy low", cnt, 8);
    chk(setupCnt == 1, "R2", "setup writes", setupCnt, 1);

    // R4: full-word fill of three pages
    for (int p = 0; p < 3; p++)
      for (int off = 0; off < 16; off++) begin
        a = pageAddr(p, off);
        shadow[int'(a)] = 16'h0000;
        access(1'b1, a, 2'b11, patt(a), lat, rd);
        chk(lat == WR_L, "R4", "write latency", lat, WR_L);
      end
    // R4: masked overwrite, be = off mod 4 (00 leaves word unchanged)
    for (int p = 0; p < 3; p++)
      for (int off = 0; off < 16; off++) begin
        a = pageAddr(p, off);
        access(1'b1, a, 2'(off % 4), ~patt(a), lat, rd);
      end
    // R5/R6/R9: read sweep
    for (int p = 0; p < 3; p++)
      for (int off = 0; off < 16; off++) begin
        a = pageAddr(p, off);
        access(1'b0, a, 2'b11, 16'h0, lat, rd);
        chk(rd == shadow[int'(a)], "R3", "read data", rd, shadow[int'(a)]);
        if (p == 0 && off == 0)
          chk(lat == LONG_L + 1, "R9", "read after write latency", lat, LONG_L + 1);
        else if (off == 0)
          chk(lat == LONG_L, "R5", "page miss latency", lat, LONG_L);
        else
          chk(lat == PAGE_L, "R6", "page hit latency", lat, PAGE_L);
      end

    // R7: write clears page record
    access(1'b1, pageAddr(0, 3), 2'b11, 16'h1234, lat, rd);
    access(1'b0, pageAddr(0, 4), 2'b11, 16'h0, lat, rd);
    chk(lat == LONG_L + 1, "R7", "read after write in same page", lat, LONG_L + 1);
    chk(rd == shadow[int'(pageAddr(0, 4))], "R7", "data", rd, shadow[int'(pageAddr(0, 4))]);
    access(1'b0, pageAddr(0, 3), 2'b11, 16'h0, lat, rd);
    chk(lat == PAGE_L, "R6", "page hit after refill", lat, PAGE_L);
    chk(rd == 16'h1234, "R4", "full write data", rd, 16'h1234);

    // R11: request while busy is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = pageAddr(1, 0); be = 2'b11;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      if (lat == 3) begin
        req = 1'b1; we = 1'b1; addr = pageAddr(1, 9); wdata = 16'hBEEF; be = 2'b11;
      end
      if (!ack) lat++;
    end while (!ack && lat < 100);
    req = 1'b0;
    chk(lat == LONG_L, "R5", "read during stray request", lat, LONG_L);
    chk(rdata == shadow[int'(pageAddr(1, 0))], "R11", "read data", rdata, shadow[int'(pageAddr(1, 0))]);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ack) extra++;
    end
    chk(extra == 0, "R11", "extra ack", extra, 0);
    access(1'b0, pageAddr(1, 9), 2'b11, 16'h0, lat, rd);
    chk(rd == shadow[int'(pageAddr(1, 9))], "R11", "word untouched", rd, shadow[int'(pageAddr(1, 9))]);
    chk(lat == PAGE_L, "R6", "page hit latency", lat, PAGE_L);

    // R10: strobes idle after ack
    access(1'b0, pageAddr(2, 5), 2'b11, 16'h0, lat, rd);
    chk(memCeN == 1'b1, "R10", "strobes idle with ack", memCeN, 1);
    @(negedge clk);
    chk(ack == 1'b0, "R10", "ack single pulse", ack, 0);

    chk(busErr == 0, "R8", "data driver outside write", busErr, 0);
    chk(setupCnt == 1, "R2", "setup writes total", setupCnt, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule